// File: doc/BRIEF.md
# RAM FIFO Pointer and Flag Controller

This block keeps the address pointers for a first-in first-out buffer that lives in ordinary RAM. A write pointer and a read pointer each step by one word for every write or read bus cycle the block sees. Each pointer wraps from the last address of a fixed region back to the first. The block leaves the data path and the RAM array to its neighbours. It only presents the current addresses and raises status flags for wrap (boundary overflow), full and empty.

A third, temporary pointer can stand in for either side. It lets one side run ahead speculatively while the committed pointer stays where it is. While it stands in, the full and empty comparisons use it in place of the pointer it replaces. Every detected condition lands in a sticky status register only when its own enable bit in a control register is set. Software clears a flag by reading the status register and then writing 0 to that bit.

Top module: `ramfifo_ptr_ctrl`

## Requirements
- R1: After reset the write, read and temporary pointers equal REGION_LO, the temporary pointer is unused, and the control and status registers read as 0.
- R2: The control register (reg_addr_i=0) holds four read/write enables. Bit 7 enables read-overflow, bit 6 write-overflow, bit 5 full and bit 4 empty. Bits 3..0 read as 0 and ignore writes. The status register is at reg_addr_i=1, with its flags in bits 3..0 and bits 7..4 reading as 0.
- R3: Each write (read) bus cycle advances the active write-side (read-side) pointer by one. A pointer at REGION_HI advances to REGION_LO, and pointers never leave the region.
- R4: A wrap of the read-side pointer sets status bit 3 only if control bit 7 is 1.
- R5: A wrap of the write-side pointer sets status bit 2 only if control bit 6 is 1.
- R6: On a write cycle, if the advanced write-side pointer equals the read-side pointer, status bit 1 is set only if control bit 5 is 1.
- R7: On a read cycle, if the advanced read-side pointer equals the write-side pointer, status bit 0 is set only if control bit 4 is 1.
- R8: tmp_sel_i=1 makes the temporary pointer the read side, and tmp_sel_i=2 makes it the write side. Values 0 and 3 leave it unused. In the cycle the selection changes to 1 or 2, the temporary pointer is first loaded from the read or the write pointer respectively. The pointer it replaces holds its value.
- R9: When a write and a read cycle fall in the same clock, the write is applied first and the empty comparison sees the advanced write side.
- R10: Status flags are sticky. A status write clears exactly those bits that are written 0 and were read as 1 by a status read since the last status write. A flag that is set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cyc_i | input | 1 | A write bus cycle to the buffer occurs this clock |
| rd_cyc_i | input | 1 | A read bus cycle from the buffer occurs this clock |
| tmp_sel_i | input | 2 | Temporary pointer role: 0 unused, 1 read side, 2 write side, 3 unused |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms status clearing) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| war_o | output | AW | Write address pointer |
| rar_o | output | AW | Read address pointer |
| tmp_o | output | AW | Temporary pointer |
| status_o | output | 4 | Status flags: 3 read-overflow, 2 write-overflow, 1 full, 0 empty |

## Verification
The hardest case to reach is full or empty decided against the temporary pointer. This needs a role change, enough accesses to bring the two sides level, and a write and a read in the same clock. The stimulus first reaches that state with a directed sequence: load the temporary pointer, advance one side past the other, then close the gap. A long random run follows. It changes the role rarely, toggles enables and issues read-then-clear pairs. A behavioural model is checked against the design on every clock throughout.

// File: rtl/ramfifo_pkg.sv
package ramfifo_pkg;

    typedef enum logic [1:0] {
        TMP_OFF  = 2'd0,
        TMP_RD   = 2'd1,
        TMP_WR   = 2'd2,
        TMP_OFF3 = 2'd3
    } tmp_mode_e;

    localparam int NFLG      = 4;
    localparam int FLG_RDOVF = 3;
    localparam int FLG_WROVF = 2;
    localparam int FLG_FULL  = 1;
    localparam int FLG_EMPTY = 0;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_STAT = 1'b1;

endpackage

// File: rtl/rf_ptr_adv.sv
module rf_ptr_adv #(
    parameter int             AW  = 8,
    parameter logic [AW-1:0]  LO  = 'h10,
    parameter logic [AW-1:0]  HI  = 'h17
) (
    input  logic [AW-1:0] ptr_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o,
    output logic          wrap_o
);
    logic at_end;

    always_comb begin
        at_end = (ptr_i == HI);
        wrap_o = step_i && at_end;
        if (!step_i) begin
            ptr_o = ptr_i;
        end else if (at_end) begin
            ptr_o = LO;
        end else begin
            ptr_o = ptr_i + AW'(1);
        end
    end

    initial begin
        assert (HI >= LO) else $error("region end below region start");
    end
endmodule

// File: rtl/rf_flag_regs.sv
module rf_flag_regs
    import ramfifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLG-1:0] det_i,
    input  logic            ctrl_we_i,
    input  logic [NFLG-1:0] ctrl_wdata_i,
    input  logic            stat_we_i,
    input  logic            stat_re_i,
    input  logic [NFLG-1:0] stat_wdata_i,
    output logic [NFLG-1:0] en_o,
    output logic [NFLG-1:0] stat_o
);
    typedef struct packed {
        logic [NFLG-1:0] en;
        logic [NFLG-1:0] stat;
        logic [NFLG-1:0] arm;
    } flag_state_t;

    flag_state_t fs_d, fs_q;
    logic [NFLG-1:0] set_v, clr_v;

    always_comb begin
        fs_d  = fs_q;
        set_v = det_i & fs_q.en;
        clr_v = stat_we_i ? (fs_q.arm & ~stat_wdata_i) : '0;
        if (ctrl_we_i) begin
            fs_d.en = ctrl_wdata_i;
        end
        fs_d.stat = (fs_q.stat & ~clr_v) | set_v;
        if (stat_re_i) begin
            fs_d.arm = fs_q.stat;
        end else if (stat_we_i) begin
            fs_d.arm = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign en_o   = fs_q.en;
    assign stat_o = fs_q.stat;

    assert_ctrl_rw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we_i |=> (en_o == $past(ctrl_wdata_i)));

    assert_rdovf_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[FLG_RDOVF] && !en_o[FLG_RDOVF]) |=> !stat_o[FLG_RDOVF]);

    assert_wrovf_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[FLG_WROVF] && !en_o[FLG_WROVF]) |=> !stat_o[FLG_WROVF]);

    assert_full_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[FLG_FULL] && !en_o[FLG_FULL]) |=> !stat_o[FLG_FULL]);

    assert_empty_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[FLG_EMPTY] && !en_o[FLG_EMPTY]) |=> !stat_o[FLG_EMPTY]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
endmodule

// File: rtl/ramfifo_ptr_ctrl.sv
module ramfifo_ptr_ctrl
    import ramfifo_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] REGION_LO = 'h10,
    parameter logic [AW-1:0] REGION_HI = 'h17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cyc_i,
    input  logic          rd_cyc_i,
    input  logic [1:0]    tmp_sel_i,
    input  logic          reg_addr_i,
    input  logic          reg_we_i,
    input  logic          reg_re_i,
    input  logic [7:0]    reg_wdata_i,
    output logic [7:0]    reg_rdata_o,
    output logic [AW-1:0] war_o,
    output logic [AW-1:0] rar_o,
    output logic [AW-1:0] tmp_o,
    output logic [3:0]    status_o
);
    localparam int CTRL_SHIFT = 8 - NFLG;

    typedef struct packed {
        logic [AW-1:0] war;
        logic [AW-1:0] rar;
        logic [AW-1:0] tmp;
        tmp_mode_e     mode;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    tmp_mode_e       mode_eff;
    logic            mode_chg;
    logic [AW-1:0]   tmp_base;
    logic [AW-1:0]   ws_cur, rs_cur, ws_nxt, rs_nxt;
    logic            ws_wrap, rs_wrap;
    logic [NFLG-1:0] det_v, en_v, stat_v;
    logic            ctrl_we, stat_we, stat_re;

    // role decode and temporary pointer load on a role change
    always_comb begin
        unique case (tmp_sel_i)
            2'd1:    mode_eff = TMP_RD;
            2'd2:    mode_eff = TMP_WR;
            default: mode_eff = TMP_OFF;
        endcase
        mode_chg = (mode_eff != st_q.mode);
        tmp_base = st_q.tmp;
        if (mode_chg && mode_eff == TMP_RD) tmp_base = st_q.rar;
        if (mode_chg && mode_eff == TMP_WR) tmp_base = st_q.war;
        ws_cur = (mode_eff == TMP_WR) ? tmp_base : st_q.war;
        rs_cur = (mode_eff == TMP_RD) ? tmp_base : st_q.rar;
    end

    rf_ptr_adv #(.AW(AW), .LO(REGION_LO), .HI(REGION_HI)) u_wside (
        .ptr_i  (ws_cur),
        .step_i (wr_cyc_i),
        .ptr_o  (ws_nxt),
        .wrap_o (ws_wrap)
    );

    rf_ptr_adv #(.AW(AW), .LO(REGION_LO), .HI(REGION_HI)) u_rside (
        .ptr_i  (rs_cur),
        .step_i (rd_cyc_i),
        .ptr_o  (rs_nxt),
        .wrap_o (rs_wrap)
    );

    // write first, then read: empty compares against the advanced write side
    always_comb begin
        det_v            = '0;
        det_v[FLG_RDOVF] = rs_wrap;
        det_v[FLG_WROVF] = ws_wrap;
        det_v[FLG_FULL]  = wr_cyc_i && (ws_nxt == rs_cur);
        det_v[FLG_EMPTY] = rd_cyc_i && (rs_nxt == ws_nxt);

        st_d      = st_q;
        st_d.mode = mode_eff;
        st_d.tmp  = tmp_base;
        if (mode_eff == TMP_WR) st_d.tmp = ws_nxt;
        else                    st_d.war = ws_nxt;
        if (mode_eff == TMP_RD) st_d.tmp = rs_nxt;
        else                    st_d.rar = rs_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.war  <= REGION_LO;
            st_q.rar  <= REGION_LO;
            st_q.tmp  <= REGION_LO;
            st_q.mode <= TMP_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_we = reg_we_i && (reg_addr_i == REG_CTRL);
    assign stat_we = reg_we_i && (reg_addr_i == REG_STAT);
    assign stat_re = reg_re_i && (reg_addr_i == REG_STAT);

    rf_flag_regs u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .det_i        (det_v),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (reg_wdata_i[7:CTRL_SHIFT]),
        .stat_we_i    (stat_we),
        .stat_re_i    (stat_re),
        .stat_wdata_i (reg_wdata_i[NFLG-1:0]),
        .en_o         (en_v),
        .stat_o       (stat_v)
    );

    always_comb begin
        if (reg_addr_i == REG_CTRL) reg_rdata_o = {en_v, {CTRL_SHIFT{1'b0}}};
        else                        reg_rdata_o = {{CTRL_SHIFT{1'b0}}, stat_v};
    end

    assign war_o    = st_q.war;
    assign rar_o    = st_q.rar;
    assign tmp_o    = st_q.tmp;
    assign status_o = stat_v;

    assert_war_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (war_o >= REGION_LO) && (war_o <= REGION_HI));

    assert_rar_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rar_o >= REGION_LO) && (rar_o <= REGION_HI));

    assert_war_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc_i && tmp_sel_i == 2'd0 && war_o == REGION_HI) |=> (war_o == REGION_LO));

    assert_rar_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmp_sel_i == 2'd1) |=> (rar_o == $past(rar_o)));

    assert_war_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmp_sel_i == 2'd2) |=> (war_o == $past(war_o)));
endmodule

// File: tb/ramfifo_ptr_ctrl_tb_top.sv
module ramfifo_ptr_ctrl_tb_top;
    localparam int LO = 16;
    localparam int HI = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_cyc = 0, rd_cyc = 0;
    logic [1:0] tmp_sel = 0;
    logic       reg_addr = 0, reg_we = 0, reg_re = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic [7:0] war, rar, tmp;
    logic [3:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ramfifo_ptr_ctrl #(.AW(8), .REGION_LO(8'(LO)), .REGION_HI(8'(HI))) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_cyc_i(wr_cyc), .rd_cyc_i(rd_cyc),
        .tmp_sel_i(tmp_sel), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
        .reg_re_i(reg_re), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .war_o(war), .rar_o(rar), .tmp_o(tmp), .status_o(status)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_war, m_rar, m_tmp, m_mode;
    bit [3:0] m_en, m_stat, m_arm;

    function automatic int nextp(int p);
        return LO + ((p - LO + 1) % (HI - LO + 1));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_war = LO; m_rar = LO; m_tmp = LO; m_mode = 0;
            m_en = 0; m_stat = 0; m_arm = 0;
        end else begin
            int nm, ws, rs;
            bit [3:0] hit, clr;
            nm = (tmp_sel == 1 || tmp_sel == 2) ? int'(tmp_sel) : 0;
            if (nm != m_mode && nm == 1) m_tmp = m_rar;
            if (nm != m_mode && nm == 2) m_tmp = m_war;
            m_mode = nm;
            ws = (nm == 2) ? m_tmp : m_war;
            rs = (nm == 1) ? m_tmp : m_rar;
            hit = 0;
            if (wr_cyc) begin
                if (ws == HI) hit[2] = 1;
                ws = nextp(ws);
                if (ws == rs) hit[1] = 1;
            end
            if (rd_cyc) begin
                if (rs == HI) hit[3] = 1;
                rs = nextp(rs);
                if (rs == ws) hit[0] = 1;
            end
            if (nm == 2) m_tmp = ws; else m_war = ws;
            if (nm == 1) m_tmp = rs; else m_rar = rs;
            clr = (reg_we && reg_addr) ? (m_arm & ~reg_wdata[3:0]) : 4'h0;
            if (reg_re && reg_addr) m_arm = m_stat;
            else if (reg_we && reg_addr) m_arm = 0;
            m_stat = (m_stat & ~clr) | (hit & m_en);
            if (reg_we && !reg_addr) m_en = reg_wdata[7:4];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 war", int'(war), m_war);
            chk("R3 rar", int'(rar), m_rar);
            chk("R8 tmp", int'(tmp), m_tmp);
            chk("R10 status", int'(status), int'(m_stat));
            chk("R2 rdata", int'(reg_rdata), reg_addr ? int'({4'h0, m_stat}) : int'({m_en, 4'h0}));
        end
    end

    task automatic cyc(bit w, bit r);
        wr_cyc = w; rd_cyc = r;
        @(posedge clk); #1;
        wr_cyc = 0; rd_cyc = 0;
    endtask

    task automatic regop(bit a, bit we, bit re, logic [7:0] d);
        reg_addr = a; reg_we = we; reg_re = re; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0; reg_re = 0;
    endtask

    task automatic clear_all();
        regop(1, 0, 1, 8'h00);
        regop(1, 1, 0, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #23;
        chk("R1 war", int'(war), LO);
        chk("R1 rar", int'(rar), LO);
        chk("R1 tmp", int'(tmp), LO);
        chk("R1 status", int'(status), 0);
        chk("R1 ctrl", int'(reg_rdata), 0);
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;

        regop(0, 1, 0, 8'hFF);
        chk("R2 ctrl low bits", int'(reg_rdata), 'hF0);

        for (int i = 0; i < 8; i++) cyc(1, 0);
        chk("R3 war wrapped", int'(war), LO);
        chk("R5 R6 status", int'(status), 'h6);
        regop(1, 1, 0, 8'h00);
        chk("R10 no read no clear", int'(status), 'h6);
        clear_all();
        chk("R10 cleared", int'(status), 0);

        for (int i = 0; i < 8; i++) cyc(0, 1);
        chk("R4 R7 status", int'(status), 'h9);
        clear_all();

        regop(0, 1, 0, 8'h00);
        for (int i = 0; i < 8; i++) cyc(1, 0);
        for (int i = 0; i < 8; i++) cyc(0, 1);
        chk("R4 R5 R6 R7 disabled", int'(status), 0);

        regop(0, 1, 0, 8'hF0);
        cyc(1, 1);
        chk("R9 same cycle", int'(status), 'h1);
        clear_all();

        tmp_sel = 2'd1;
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        cyc(0, 1); cyc(0, 1);
        chk("R8 rar held", int'(rar), 17);
        chk("R8 tmp read side", int'(tmp), 19);
        chk("R8 no empty yet", int'(status), 0);
        cyc(0, 1);
        chk("R7 R8 empty on tmp", int'(status), 'h1);
        clear_all();
        tmp_sel = 2'd2;
        cyc(1, 0);
        chk("R8 war held", int'(war), 20);
        chk("R8 tmp write side", int'(tmp), 21);
        tmp_sel = 2'd0;
        cyc(0, 0);

        for (int i = 0; i < 6000; i++) begin
            int k;
            wr_cyc = 1'($urandom_range(0, 1));
            rd_cyc = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 19) == 0) tmp_sel = 2'($urandom_range(0, 3));
            k = $urandom_range(0, 15);
            reg_addr = 1'($urandom_range(0, 1));
            reg_we = (k == 0 || k == 1);
            reg_re = (k == 1 || k == 2 || k == 3);
            reg_wdata = 8'($urandom);
            @(posedge clk); #1;
        end
        wr_cyc = 0; rd_cyc = 0; reg_we = 0; reg_re = 0;
        @(posedge clk); #1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule